// File: doc/BRIEF.md
# Shared Program/Data Memory Arbiter

This block lets two bus masters, a small processor core and a USB device controller, share a program ROM and a data SRAM. Each memory has its own bus, so both masters can be served in one clock when they target different memories. The processor names its target memory with a select input. The USB side uses a single address space: the upper address nibble chooses between the memories, and the descriptor tables live in the ROM window.

The processor is never stalled. When the USB controller collides with it on a memory, the USB request is parked inside the arbiter and reissued on every following clock until that memory is free. While a request is parked, new USB requests are held off through a ready output. The ROM is read-only from the USB side. A USB write aimed at the ROM window is dropped and reported with an error pulse. Read data comes back one clock after the grant, together with a valid strobe for each master.

Top module: `memarb`

## Requirements
- R1: `m_gnt` equals `m_req` in the same cycle. A granted processor access is driven onto the ROM bus when `m_rom` is 1 and onto the SRAM bus when it is 0. Processor ROM accesses are always reads.
- R2: A USB access targets the ROM when `u_addr[11:8]` is nonzero (0x100..0xFFF). Otherwise it targets the SRAM at `u_addr[7:0]`. 0x0FF is the highest SRAM address and 0x100 is the lowest ROM address.
- R3: A USB read of the ROM returns bits [7:0] of the 14-bit ROM word on `u_rdata`.
- R4: When both masters want the ROM in the same cycle, the processor is granted and `u_gnt` stays 0.
- R5: When both masters want the SRAM in the same cycle, the processor is granted and `u_gnt` stays 0.
- R6: When the masters want different memories in the same cycle, both are granted in that cycle.
- R7: A USB request that loses arbitration is kept, with its address, write flag and data, and reissued every cycle until it is granted. `u_ready` is 0 from the cycle after the loss until the cycle after the grant. While `u_ready` is 0, `u_req` is ignored.
- R8: A USB write to the ROM window is not granted and reaches no bus. `u_err` pulses one cycle later, and `u_rvalid` stays 0.
- R9: `m_rvalid` and `u_rvalid` pulse one cycle after the grant of a read, and the matching data is valid in that cycle. A granted write gives no valid pulse.
- R10: During reset `u_ready` is 1, and `m_rvalid`, `u_rvalid` and `u_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req | input | 1 | Processor access request |
| m_rom | input | 1 | Processor target: 1 selects ROM, 0 selects SRAM |
| m_we | input | 1 | Processor write (SRAM only) |
| m_addr | input | 12 | Processor address |
| m_wdata | input | 8 | Processor write data |
| m_gnt | output | 1 | Processor grant |
| m_rvalid | output | 1 | Processor read data valid |
| m_rdata | output | 14 | Processor read data |
| u_req | input | 1 | USB access request, sampled while u_ready is 1 |
| u_we | input | 1 | USB write |
| u_addr | input | 12 | USB address (upper nibble selects the memory) |
| u_wdata | input | 8 | USB write data |
| u_ready | output | 1 | No USB request is parked |
| u_gnt | output | 1 | USB access issued to a memory this cycle |
| u_rvalid | output | 1 | USB read data valid |
| u_rdata | output | 8 | USB read data |
| u_err | output | 1 | Pulse for a dropped USB ROM write |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 12 | ROM word address |
| rom_q | input | 14 | ROM read data, one cycle after rom_en |
| ram_en | output | 1 | SRAM enable |
| ram_we | output | 1 | SRAM write enable |
| ram_addr | output | 8 | SRAM address |
| ram_wdata | output | 8 | SRAM write data |
| ram_q | input | 8 | SRAM read data, one cycle after ram_en |

## Verification
The bench targets the decode boundary at 0x0FF/0x100. A decoder that tests the wrong bits would send a descriptor read into the SRAM or return an SRAM byte from the ROM.

Collisions on each memory are held for several cycles. This exposes a parked request that is dropped, reissued with the live inputs instead of the captured ones, or granted while the processor still owns the bus. Split accesses check that both masters are served together, not serialised. ROM-window writes check that no SRAM location changes, that an error pulse appears, and that no read strobe follows.

// File: rtl/memarb.sv
module memarb #(
  parameter int ROM_AW = 12,
  parameter int RAM_AW = 8,
  parameter int ROM_DW = 14,
  parameter int RAM_DW = 8,
  parameter int WIN_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req,
  input  logic              m_rom,
  input  logic              m_we,
  input  logic [ROM_AW-1:0] m_addr,
  input  logic [RAM_DW-1:0] m_wdata,
  output logic              m_gnt,
  output logic              m_rvalid,
  output logic [ROM_DW-1:0] m_rdata,
  input  logic              u_req,
  input  logic              u_we,
  input  logic [ROM_AW-1:0] u_addr,
  input  logic [RAM_DW-1:0] u_wdata,
  output logic              u_ready,
  output logic              u_gnt,
  output logic              u_rvalid,
  output logic [RAM_DW-1:0] u_rdata,
  output logic              u_err,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [ROM_DW-1:0] rom_q,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [RAM_DW-1:0] ram_wdata,
  input  logic [RAM_DW-1:0] ram_q
);

  logic              pend;
  logic              h_we;
  logic [ROM_AW-1:0] h_addr;
  logic [RAM_DW-1:0] h_wdata;
  logic              m_src, u_src;

  wire              c_vld   = pend | u_req;
  wire              c_we    = pend ? h_we : u_we;
  wire [ROM_AW-1:0] c_addr  = pend ? h_addr : u_addr;
  wire [RAM_DW-1:0] c_wdata = pend ? h_wdata : u_wdata;
  wire              c_rom   = |c_addr[ROM_AW-1:WIN_LO];
  wire              c_bad   = c_vld & c_we & c_rom;
  wire              c_hit   = m_req & (m_rom == c_rom);
  wire              lose    = c_vld & ~c_bad & c_hit;
  wire              m_racc  = m_req & m_rom;
  wire              m_sacc  = m_req & ~m_rom;

  assign m_gnt   = m_req;
  assign u_gnt   = c_vld & ~c_bad & ~c_hit;
  assign u_ready = ~pend;

  assign rom_en    = m_racc | (u_gnt & c_rom);
  assign rom_addr  = m_racc ? m_addr : c_addr;
  assign ram_en    = m_sacc | (u_gnt & ~c_rom);
  assign ram_we    = m_sacc ? m_we : c_we;
  assign ram_addr  = m_sacc ? m_addr[RAM_AW-1:0] : c_addr[RAM_AW-1:0];
  assign ram_wdata = m_sacc ? m_wdata : c_wdata;

  assign m_rdata = m_src ? rom_q : {{(ROM_DW-RAM_DW){1'b0}}, ram_q};
  assign u_rdata = u_src ? rom_q[RAM_DW-1:0] : ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      h_we     <= 1'b0;
      h_addr   <= '0;
      h_wdata  <= '0;
      m_rvalid <= 1'b0;
      m_src    <= 1'b0;
      u_rvalid <= 1'b0;
      u_src    <= 1'b0;
      u_err    <= 1'b0;
    end else begin
      pend <= lose;
      if (lose && !pend) begin
        h_we    <= u_we;
        h_addr  <= u_addr;
        h_wdata <= u_wdata;
      end
      m_rvalid <= m_req & (m_rom | ~m_we);
      m_src    <= m_rom;
      u_rvalid <= u_gnt & ~c_we;
      u_src    <= c_rom;
      u_err    <= c_bad;
    end
  end

  AST_SPLIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_gnt && u_gnt) |-> (rom_en && ram_en)); // R6
  AST_PARK_AFTER_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !u_ready |-> $past(m_req && !u_gnt)); // R7
  AST_ROMWR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    u_err |-> !u_rvalid); // R8
  AST_U_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    u_rvalid |-> $past(u_gnt)); // R9
  AST_M_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> $past(m_gnt)); // R9
  AST_MCU_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (rom_en || ram_en)); // R1

endmodule

// File: tb/sim_memarb.sv
`timescale 1ns/1ps
module sim_memarb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_req = 0, m_rom = 0, m_we = 0;
  logic [11:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  logic u_req = 0, u_we = 0;
  logic [11:0] u_addr = '0;
  logic [7:0]  u_wdata = '0;
  logic m_gnt, m_rvalid, u_ready, u_gnt, u_rvalid, u_err;
  logic [13:0] m_rdata;
  logic [7:0]  u_rdata;
  logic rom_en, ram_en, ram_we;
  logic [11:0] rom_addr;
  logic [7:0]  ram_addr, ram_wdata;
  logic [13:0] rom_q;
  logic [7:0]  ram_q;

  memarb u0 (.*);

  function automatic logic [13:0] rom_word(logic [11:0] a);
    logic [31:0] t;
    t = {20'd0, a} * 32'd733 + 32'd91;
    return t[13:0] ^ {2'b00, a};
  endfunction

  logic [7:0] ram [256];
  always_ff @(posedge clk) begin
    if (rom_en) rom_q <= rom_word(rom_addr);
    if (ram_en) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      ram_q <= ram[ram_addr];
    end
  end

  typedef struct packed { logic [11:0] a; logic we; logic [7:0] d; } ureq_t;
  ureq_t hq[$];
  logic [7:0] mram [256];
  logic x_mv = 0, x_uv = 0, x_ue = 0;
  logic [13:0] x_md = '0;
  logic [7:0] x_ud = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(string tag);
    ureq_t cur;
    bit cv, crom, bad, lose, eg;
    #1;
    chk("R9", "m_rvalid", m_rvalid, x_mv);
    chk("R9", "u_rvalid", u_rvalid, x_uv);
    chk("R8", "u_err", u_err, x_ue);
    if (x_mv) chk("R1", "m_rdata", m_rdata, x_md);
    if (x_uv) chk("R3", "u_rdata", u_rdata, x_ud);
    cv = 0; cur = '0;
    if (hq.size() > 0) begin cv = 1; cur = hq[0]; end
    else if (u_req) begin cv = 1; cur = '{a: u_addr, we: u_we, d: u_wdata}; end
    crom = (cur.a[11:8] != 4'd0);
    bad  = cv && cur.we && crom;
    lose = cv && !bad && m_req && (m_rom == crom);
    eg   = cv && !bad && !lose;
    chk("R1", "m_gnt", m_gnt, m_req);
    chk(tag, "u_gnt", u_gnt, eg);
    chk("R7", "u_ready", u_ready, hq.size() == 0);
    chk("R2", "rom_en", rom_en, (m_req && m_rom) || (eg && crom));
    chk("R2", "ram_en", ram_en, (m_req && !m_rom) || (eg && !crom));
    x_mv = m_req && (m_rom || !m_we);
    x_md = m_rom ? rom_word(m_addr) : {6'd0, mram[m_addr[7:0]]};
    if (m_req && !m_rom && m_we) mram[m_addr[7:0]] = m_wdata;
    x_uv = eg && !cur.we;
    x_ue = bad;
    x_ud = crom ? rom_word(cur.a) : {6'd0, mram[cur.a[7:0]]};
    if (eg && cur.we) mram[cur.a[7:0]] = cur.d;
    if (lose && hq.size() == 0) hq.push_back(cur);
    if (eg && hq.size() > 0) void'(hq.pop_front());
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    m_req = 0; m_we = 0; u_req = 0; u_we = 0;
  endtask

  task automatic mcu(bit rom, bit we, logic [11:0] a, logic [7:0] d);
    m_req = 1; m_rom = rom; m_we = we; m_addr = a; m_wdata = d;
  endtask

  task automatic usb(bit we, logic [11:0] a, logic [7:0] d);
    u_req = 1; u_we = we; u_addr = a; u_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 8'd0; mram[i] = 8'd0; end
    repeat (3) @(negedge clk);
    chk("R10", "u_ready in reset", u_ready, 1);
    chk("R10", "m_rvalid in reset", m_rvalid, 0);
    chk("R10", "u_rvalid in reset", u_rvalid, 0);
    chk("R10", "u_err in reset", u_err, 0);
    rst_n = 1;
    @(negedge clk);

    usb(1, 12'h010, 8'hA5); step("R2");
    usb(0, 12'h010, 8'h00); step("R2");
    usb(0, 12'h0FF, 8'h00); step("R2");
    usb(0, 12'h100, 8'h00); step("R3");
    usb(0, 12'h123, 8'h00); step("R3");
    usb(0, 12'hFFF, 8'h00); step("R3");
    idle(); step("R9");

    mcu(0, 0, 12'h010, 0); usb(0, 12'h011, 0); step("R5");
    idle(); u_req = 1; u_addr = 12'h0AA; step("R7");
    idle(); step("R7");

    mcu(1, 0, 12'h300, 0); usb(0, 12'h200, 0); step("R4");
    usb(0, 12'h005, 0); step("R4");
    step("R4");
    idle(); step("R7");
    step("R7");

    mcu(0, 1, 12'h020, 8'h3C); usb(1, 12'h021, 8'h77); step("R5");
    idle(); step("R7");
    usb(0, 12'h021, 0); step("R7");
    usb(0, 12'h020, 0); step("R1");

    mcu(1, 0, 12'h456, 0); usb(0, 12'h010, 0); step("R6");
    mcu(0, 0, 12'h010, 0); usb(0, 12'h456, 0); step("R6");
    mcu(0, 1, 12'h030, 8'h99); usb(0, 12'hABC, 0); step("R6");

    idle(); usb(1, 12'h200, 8'hEE); step("R8");
    usb(0, 12'h200, 0); step("R8");
    usb(0, 12'h000, 0); step("R8");
    mcu(1, 0, 12'h200, 0); usb(1, 12'h800, 8'h11); step("R8");
    idle(); step("R8");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      m_req = r[0] | r[1];
      m_rom = r[2];
      m_we = r[3] & r[4];
      m_addr = {r[5] ? 4'h1 : 4'h0, r[13:6]};
      m_wdata = r[21:14];
      u_req = r[22] | r[23];
      u_we = r[24] & r[25];
      u_addr = {r[26] ? r[30:27] : 4'h0, r[31:24]};
      u_wdata = r[15:8];
      step("R7");
    end
    idle(); step("R9"); step("R9");
    finish_run();
  end
endmodule